// File: doc/BRIEF.md
# Host Firmware Window Address Remapper

This block takes addresses from the host side of a firmware-space bus and places them inside a window of the local address space. Translation works one bit at a time and does not add an offset to a base. In the upper sixteen address bits, each position is either copied from the request, replaced by a programmed prefix bit, or driven to zero. The lower sixteen bits always pass straight through. The window therefore has a 64 KiB granularity.

Three 32-bit control words set up the window, and a small synchronous write port with a combinational read port loads them:

- **Control word (offset 0x0).** Two gate bits, bit 8 and bit 10, must both be set before any request can hit.
- **Prefix word (offset 0x8).** The high half holds the local target prefix. The low half holds the host window prefix.
- **Mask word (offset 0xC).** The high half selects the bits to replace. The low half selects the bits to keep from the request.

For a window of size S at an offset that is a multiple of S, software writes:

- the mask word as the upper half of ~(S-1) joined to (S>>16)-1;
- the prefix word as the local target address ORed with the host address shifted down by sixteen.

The hit flag and the translated address depend combinationally on the request and on the current register contents. On a miss the output address is zero.

Top module: `fw_remap_window`

## Requirements
- R1: While reset is asserted and right after it, all three registers read back as zero, `win_hit` is 0 and `loc_addr` is zero.
- R2: A write with `cfg_we` high at offset 0x0, 0x8 or 0xC stores all 32 bits of `cfg_wdata` on the rising clock edge. From then on, reading that offset returns the stored word combinationally.
- R3: Writes to any other offset change no register. Reads from any other offset return zero.
- R4: A request can hit only when bit 8 and bit 10 of the control word are both 1. With either bit clear, `win_hit` is 0.
- R5: When enabled, a request hits exactly when, at every position where the mask low half is 0, request bits 31:16 equal the prefix low half.
- R6: On a hit, `loc_addr[31:16]` = (request[31:16] AND mask low half) OR (prefix high half AND mask high half).
- R7: On a hit, `loc_addr[15:0]` equals `req_addr[15:0]`.
- R8: On a miss, `loc_addr` is all zeros.
- R9: A register write takes effect on the translation of an unchanged request right after the write edge, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Full-word register write enable |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_addr | input | 32 | Host firmware-space request address |
| loc_addr | output | 32 | Translated local address, zero on miss |
| win_hit | output | 1 | Request falls inside the enabled window |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit pass-through field, and the gate bits at positions 8 and 10. These defaults place the control offsets at 0x0, 0x8 and 0xC, with 0x4 left as an unmapped gap for the ignored-write checks.

The random part biases both gate bits on. Half of the requests are drawn so that they agree with the host prefix outside the kept bits, which makes hits, misses, overlapping keep/replace masks and bits owned by neither mask all common. A directed 1 MiB window then checks the size-derived mask encoding, and each gate bit is checked on its own.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W   = 32;
  localparam int PASS_W   = 16;
  localparam int HI_W     = ADDR_W - PASS_W;
  localparam int OFS_W    = 4;
  localparam int NUM_REGS = 3;

  localparam logic [OFS_W-1:0] OFS_CTRL   = 4'h0;
  localparam logic [OFS_W-1:0] OFS_PREFIX = 4'h8;
  localparam logic [OFS_W-1:0] OFS_MASK   = 4'hC;

  localparam int GATE_BRIDGE_BIT = 8;
  localparam int GATE_FWH_BIT    = 10;

  typedef enum logic [1:0] {
    RIDX_CTRL   = 2'd0,
    RIDX_PREFIX = 2'd1,
    RIDX_MASK   = 2'd2
  } reg_idx_e;

  // Window is active only with both gate bits set.
  function automatic logic gates_open(input logic g_bridge, input logic g_fwh);
    return g_bridge & g_fwh;
  endfunction

  // One bit of the substituted upper address.
  function automatic logic subst_bit(input logic req_b, input logic keep_b,
                                     input logic pfx_b, input logic repl_b);
    return (req_b & keep_b) | (pfx_b & repl_b);
  endfunction

  // One bit of the window compare: 1 means this position disagrees.
  function automatic logic diff_bit(input logic req_b, input logic win_b,
                                    input logic keep_b);
    return (~keep_b) & (req_b ^ win_b);
  endfunction
endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter int DW          = 2 * HI_W,
  parameter int BRIDGE_BIT  = GATE_BRIDGE_BIT,
  parameter int FWH_BIT     = GATE_FWH_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFS_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             gate_bridge,
  output logic             gate_fwh,
  output logic [DW-1:0]    prefix_word,
  output logic [DW-1:0]    mask_word
);
  localparam logic [OFS_W-1:0] REG_OFS [NUM_REGS] = '{OFS_CTRL, OFS_PREFIX, OFS_MASK};

  logic [NUM_REGS-1:0][DW-1:0] regs_q;
  logic [NUM_REGS-1:0]         sel;
  logic                        addr_known;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign sel[i] = (addr == REG_OFS[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (we && sel[i]) begin
        regs_q[i] <= wdata;
      end
    end
  end

  assign addr_known = |sel;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rdata = rdata | regs_q[i];
    end
  end

  assign gate_bridge = regs_q[RIDX_CTRL][BRIDGE_BIT];
  assign gate_fwh    = regs_q[RIDX_CTRL][FWH_BIT];
  assign prefix_word = regs_q[RIDX_PREFIX];
  assign mask_word   = regs_q[RIDX_MASK];

  // R1: reset clears every register
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (regs_q == '0));

  // R2: a mapped write lands in full
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_MASK) |=> (mask_word == $past(wdata)));

  assert_prefix_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_PREFIX) |=> (prefix_word == $past(wdata)));

  // R3: stray writes change nothing
  assert_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr_known) |=> $stable(regs_q));
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int PW  = PASS_W,
  localparam int HW = AW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_bridge,
  input  logic          gate_fwh,
  input  logic [2*HW-1:0] prefix_word,
  input  logic [2*HW-1:0] mask_word,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] loc_addr,
  output logic          hit
);
  logic [HW-1:0] req_hi, win_pfx, loc_pfx, keep_m, repl_m;
  logic [HW-1:0] xl_hi, mismatch;
  logic          enabled, in_window;

  assign req_hi  = req_addr[AW-1:PW];
  assign win_pfx = prefix_word[HW-1:0];
  assign loc_pfx = prefix_word[2*HW-1:HW];
  assign keep_m  = mask_word[HW-1:0];
  assign repl_m  = mask_word[2*HW-1:HW];

  for (genvar b = 0; b < HW; b++) begin : g_bit
    assign xl_hi[b]    = subst_bit(req_hi[b], keep_m[b], loc_pfx[b], repl_m[b]);
    assign mismatch[b] = diff_bit(req_hi[b], win_pfx[b], keep_m[b]);
  end

  assign enabled   = gates_open(gate_bridge, gate_fwh);
  assign in_window = ~|mismatch;
  assign hit       = enabled & in_window;
  assign loc_addr  = hit ? {xl_hi, req_addr[PW-1:0]} : '0;

  // R4: no hit without both gate bits
  assert_gate_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (gate_bridge && gate_fwh));

  // R6: kept-only bits follow the request
  assert_keep_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (((loc_addr[AW-1:PW] ^ req_hi) & keep_m & ~repl_m) == '0));

  // R7: page offset passes through
  assert_pass_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (loc_addr[PW-1:0] == req_addr[PW-1:0]));

  // R8: a miss yields zero
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (loc_addr == '0));
endmodule

// File: rtl/fw_remap_window.sv
module fw_remap_window
  import remap_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int PW         = PASS_W,
  parameter int BRIDGE_BIT = GATE_BRIDGE_BIT,
  parameter int FWH_BIT    = GATE_FWH_BIT,
  localparam int HW        = AW - PW,
  localparam int DW        = 2 * HW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFS_W-1:0] cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic [AW-1:0]    req_addr,
  output logic [AW-1:0]    loc_addr,
  output logic             win_hit
);
  logic          gate_bridge, gate_fwh;
  logic [DW-1:0] prefix_word, mask_word;

  remap_regs #(
    .DW(DW), .BRIDGE_BIT(BRIDGE_BIT), .FWH_BIT(FWH_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .gate_bridge(gate_bridge), .gate_fwh(gate_fwh),
    .prefix_word(prefix_word), .mask_word(mask_word)
  );

  remap_xlate #(.AW(AW), .PW(PW)) u_xlate (
    .clk(clk), .rst_n(rst_n),
    .gate_bridge(gate_bridge), .gate_fwh(gate_fwh),
    .prefix_word(prefix_word), .mask_word(mask_word),
    .req_addr(req_addr), .loc_addr(loc_addr), .hit(win_hit)
  );
endmodule

// File: tb/tb_fw_remap_window.sv
module tb_fw_remap_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] req_addr = '0;
  logic [31:0] loc_addr;
  logic        win_hit;

  int n_chk = 0;
  int n_bad = 0;

  fw_remap_window dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .loc_addr(loc_addr), .win_hit(win_hit)
  );

  always #2 clk = ~clk;

  // Mirror of the programmed words, kept by the bench
  logic [31:0] m_ctrl = '0, m_pfx = '0, m_mask = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      4'h0: m_ctrl = d;
      4'h8: m_pfx  = d;
      4'hC: m_mask = d;
      default: ;
    endcase
  endtask

  function automatic logic exp_hit(input logic [31:0] c, p, m, r);
    logic on;
    on = c[8] && c[10];
    for (int b = 0; b < 16; b++) begin
      if (!m[b] && (r[16+b] != p[b])) return 1'b0;
    end
    return on;
  endfunction

  function automatic logic [31:0] exp_loc(input logic [31:0] c, p, m, r);
    logic [31:0] o;
    if (!exp_hit(c, p, m, r)) return 32'h0;
    o = {16'h0, r[15:0]};
    for (int b = 0; b < 16; b++) begin
      if (m[b] && r[16+b]) o[16+b] = 1'b1;
      if (m[16+b] && p[16+b]) o[16+b] = 1'b1;
    end
    return o;
  endfunction

  task automatic probe(input string req, input logic [31:0] r);
    req_addr = r;
    #1;
    check({req, " hit"}, {31'h0, win_hit}, {31'h0, exp_hit(m_ctrl, m_pfx, m_mask, r)});
    check({req, " loc"}, loc_addr, exp_loc(m_ctrl, m_pfx, m_mask, r));
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    rd("R1 ctrl", 4'h0, 32'h0);
    rd("R1 prefix", 4'h8, 32'h0);
    rd("R1 mask", 4'hC, 32'h0);
    req_addr = 32'h1234_5678;
    #1;
    check("R1 hit", {31'h0, win_hit}, 32'h0);
    check("R1 loc", loc_addr, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 after release", 4'h0, 32'h0);

    // R2: readback
    wr(4'h0, 32'hA5A5_5A5A); rd("R2 ctrl", 4'h0, 32'hA5A5_5A5A);
    wr(4'h8, 32'h1357_9BDF); rd("R2 prefix", 4'h8, 32'h1357_9BDF);
    wr(4'hC, 32'hFFFF_0000); rd("R2 mask", 4'hC, 32'hFFFF_0000);

    // R3: unmapped offsets
    wr(4'h4, 32'hDEAD_BEEF);
    rd("R3 read gap", 4'h4, 32'h0);
    rd("R3 ctrl kept", 4'h0, 32'hA5A5_5A5A);
    rd("R3 prefix kept", 4'h8, 32'h1357_9BDF);
    rd("R3 mask kept", 4'hC, 32'hFFFF_0000);
    wr(4'hF, 32'hFFFF_FFFF);
    rd("R3 read F", 4'hF, 32'h0);
    rd("R3 mask kept2", 4'hC, 32'hFFFF_0000);

    // Directed 1 MiB window: local 0x9A30_0000, host 0x0FE0_0000
    wr(4'h0, 32'h0000_0000);
    wr(4'h8, 32'h9A30_0FE0);
    wr(4'hC, 32'hFFF0_000F);
    req_addr = 32'h0FE4_1234;
    #1;
    check("R4 gates off", {31'h0, win_hit}, 32'h0);
    check("R8 gates off loc", loc_addr, 32'h0);
    wr(4'h0, 32'h0000_0100);
    #1;
    check("R4 bridge only", {31'h0, win_hit}, 32'h0);
    wr(4'h0, 32'h0000_0400);
    #1;
    check("R4 fwh only", {31'h0, win_hit}, 32'h0);
    wr(4'h0, 32'h0000_0500);
    #1;
    check("R9 hit after write", {31'h0, win_hit}, 32'h1);
    check("R6 R7 directed loc", loc_addr, 32'h9A34_1234);
    req_addr = 32'h0FF0_0000;
    #1;
    check("R5 outside window", {31'h0, win_hit}, 32'h0);
    check("R8 outside loc", loc_addr, 32'h0);
    req_addr = 32'h0FEF_FFFF;
    #1;
    check("R5 top of window", loc_addr, 32'h9A3F_FFFF);
    wr(4'h8, 32'h4000_0FE0);
    #1;
    check("R9 new prefix", loc_addr, 32'h400F_FFFF);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [31:0] c, p, m, r;
      c = $urandom;
      if ($urandom_range(3) != 0) c = c | 32'h0000_0500;
      p = $urandom;
      m = $urandom;
      if ($urandom_range(1) == 0) m[31:16] = ~m[15:0];
      r = $urandom;
      if ($urandom_range(1) == 0) r[31:16] = (p[15:0] & ~m[15:0]) | (r[31:16] & m[15:0]);
      wr(4'h0, c);
      wr(4'h8, p);
      wr(4'hC, m);
      probe("R4 R5 R6 R7 R8 random", r);
      probe("R5 R6 R7 random2", $urandom);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule